// File: doc/BRIEF.md
# Module Clock Enable Sequencer

This block switches one peripheral module's functional clock on or off. It owns that module's control register. For a request it first rewrites the two-bit mode field of the register. It then watches the two-bit idle-status field that the module reports back, and ends the sequence when the wanted state appears or when a microsecond budget runs out. A requester raises `req_valid` for one cycle and gives the direction and supervision flavour with it. The requester then waits for the one-cycle `done` pulse, which carries the error flag and the warning flag. Software can read and write the same control register through a simple single-register port.

Enabling and disabling complete in different ways. An enable succeeds on either of two status codes, and when its budget runs out it reports an error. A disable succeeds on only one status code, and when its budget runs out it reports only a warning, never an error. A skip flag drops the status wait altogether. A zero enable encoding makes every request an immediate no-op.

The sequence runs through these states:
- **IDLE**: accepts a request.
- **APPLY**: writes the mode field and clears the timer.
- **POLL**: watches the status field and counts ticks.
- **DONE**: pulses `done` with the outcome flags.

Transitions:
- IDLE→APPLY on a request with a non-zero encoding.
- IDLE→DONE on a request with a zero encoding.
- APPLY→DONE when skip is set.
- APPLY→POLL otherwise.
- POLL→DONE on a status match or on expiry.
- DONE→IDLE always.

Top module: `mclk_seq`

## Requirements
- R1: After reset the stored register is all zero and `busy`, `done`, `err`, `tmo_warn` and `enabled` are low.
- R2: A software write (`reg_we`) stores every bit except [17:16]. A read returns the stored bits, with [17:16] taken live from `mod_status`.
- R3: An enable request sets mode field [1:0] to `cfg_mode` (01 hardware-supervised, 10 software-supervised) and keeps all other bits.
- R4: A disable request clears mode field [1:0] to 00 and keeps all other bits.
- R5: An enable wait ends without error when the status reads 00 (functional) or 10 (interface idle). Codes 01 and 11 keep it waiting. With a ready status, `done` comes three cycles after the request cycle.
- R6: A disable wait ends only when the status reads 11 (disabled).
- R7: If an enable wait sees no ready status within EN_LIMIT_US ticks of `tick_us`, `done` pulses with `err` high. The tick count restarts from zero for every request.
- R8: If a disable wait sees no 11 within DIS_LIMIT_US ticks, `done` pulses with `tmo_warn` high and `err` low. A disable never raises `err`.
- R9: With `skip_wait` set, `done` comes two cycles after the request cycle, with no polling and no flags.
- R10: With `cfg_mode` = 00, a request gives `done` one cycle later and leaves the register unchanged.
- R11: `busy` is high from acceptance until the `done` cycle. Requests arriving meanwhile are ignored and get no `done` of their own.
- R12: `enabled` is high when any bit set in `cfg_mode` is also set in the mode field.
- R13: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_on | input | 1 | 1 = enable, 0 = disable |
| cfg_mode | input | 2 | Enable encoding: 01 hardware, 10 software, 00 none |
| skip_wait | input | 1 | Finish right after the register write |
| mod_status | input | 2 | Idle status reported by the module |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| reg_we | input | 1 | Software register write strobe |
| reg_wdata | input | DW | Software write data |
| reg_rdata | output | DW | Register read value |
| mode_out | output | 2 | Mode field driven to the module |
| enabled | output | 1 | Enabled query result |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Enable failed (valid with done) |
| tmo_warn | output | 1 | Disable timed out (valid with done) |

## Verification
The bench builds the block with EN_LIMIT_US = 20 and DIS_LIMIT_US = 50 in place of the microsecond-scale defaults. With those values both timeout paths, and the restart of the count between requests, finish within a few hundred cycles. `tick_us` pulses on every second cycle, so a timer that ignored the tick would end each wait at about half the expected length, and the latency window check would catch it.

// File: rtl/mclk_seq_pkg.sv
package mclk_seq_pkg;
    typedef enum logic [1:0] {S_IDLE, S_APPLY, S_POLL, S_DONE} seq_state_t;

    localparam int MODE_LSB = 0;
    localparam int STAT_LSB = 16;

    localparam logic [1:0] ST_FUNC   = 2'b00;
    localparam logic [1:0] ST_IFIDLE = 2'b10;
    localparam logic [1:0] ST_OFF    = 2'b11;
    localparam logic [1:0] MODE_OFF  = 2'b00;
endpackage

// File: rtl/mclk_ctl_reg.sv
module mclk_ctl_reg
    import mclk_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [DW-1:0] sw_wdata,
    input  logic          seq_we,
    input  logic [1:0]    seq_mode,
    input  logic [1:0]    mod_status,
    output logic [DW-1:0] rdata
);
    localparam logic [DW-1:0] STAT_MASK = DW'(3) << STAT_LSB;

    logic [DW-1:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (seq_we) begin
            store_q[MODE_LSB +: 2] <= seq_mode;
        end else if (sw_we) begin
            store_q <= sw_wdata & ~STAT_MASK;
        end
    end

    always_comb begin
        rdata = store_q;
        rdata[STAT_LSB +: 2] = mod_status;
    end

    // R3
    seq_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |=> (store_q[DW-1:2] == $past(store_q[DW-1:2])));

    // R2
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !seq_we) |=> (rdata[1:0] == $past(sw_wdata[1:0])));
endmodule

// File: rtl/mclk_us_timer.sv
module mclk_us_timer #(
    parameter int MAX_US = 5000,
    localparam int CW = $clog2(MAX_US + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && tick && (cnt_q != CW'(MAX_US))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

    // R7
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && (limit != '0)) |=> !expired);
endmodule

// File: rtl/mclk_seq.sv
module mclk_seq
    import mclk_seq_pkg::*;
#(
    parameter int DW           = 32,
    parameter int EN_LIMIT_US  = 2000,
    parameter int DIS_LIMIT_US = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_on,
    input  logic [1:0]    cfg_mode,
    input  logic          skip_wait,
    input  logic [1:0]    mod_status,
    input  logic          tick_us,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [1:0]    mode_out,
    output logic          enabled,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          tmo_warn
);
    localparam int MAX_US = (EN_LIMIT_US > DIS_LIMIT_US) ? EN_LIMIT_US : DIS_LIMIT_US;
    localparam int CW     = $clog2(MAX_US + 1);

    seq_state_t state_q, state_nx;
    logic       dir_q, skip_q, err_q, warn_q;
    logic       err_nx, warn_nx;
    logic [1:0] enc_q;
    logic       seq_we, tmr_clear, tmr_run, tmr_exp, hit;
    logic [1:0] seq_mode;
    logic [CW-1:0] lim;

    assign hit = dir_q ? ((mod_status == ST_FUNC) || (mod_status == ST_IFIDLE))
                       : (mod_status == ST_OFF);
    assign lim = dir_q ? CW'(EN_LIMIT_US) : CW'(DIS_LIMIT_US);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
            skip_q  <= 1'b0;
            enc_q   <= 2'b00;
            err_q   <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            err_q   <= err_nx;
            warn_q  <= warn_nx;
            if (state_q == S_IDLE && req_valid) begin
                dir_q  <= req_on;
                skip_q <= skip_wait;
                enc_q  <= cfg_mode;
            end
        end
    end

    always_comb begin
        state_nx  = state_q;
        err_nx    = err_q;
        warn_nx   = warn_q;
        seq_we    = 1'b0;
        seq_mode  = dir_q ? enc_q : MODE_OFF;
        tmr_clear = 1'b0;
        tmr_run   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                err_nx  = 1'b0;
                warn_nx = 1'b0;
                if (req_valid) begin
                    state_nx = (cfg_mode == MODE_OFF) ? S_DONE : S_APPLY;
                end
            end
            S_APPLY: begin
                seq_we    = 1'b1;
                tmr_clear = 1'b1;
                state_nx  = skip_q ? S_DONE : S_POLL;
            end
            S_POLL: begin
                tmr_run = 1'b1;
                if (hit) begin
                    state_nx = S_DONE;
                end else if (tmr_exp) begin
                    state_nx = S_DONE;
                    err_nx   = dir_q;
                    warn_nx  = !dir_q;
                end
            end
            S_DONE: begin
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);
    assign err      = done && err_q;
    assign tmo_warn = done && warn_q;
    assign mode_out = reg_rdata[MODE_LSB +: 2];
    assign enabled  = |(mode_out & cfg_mode);

    mclk_ctl_reg #(.DW(DW)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (reg_we),
        .sw_wdata   (reg_wdata),
        .seq_we     (seq_we),
        .seq_mode   (seq_mode),
        .mod_status (mod_status),
        .rdata      (reg_rdata)
    );

    mclk_us_timer #(.MAX_US(MAX_US)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .tick    (tick_us),
        .limit   (lim),
        .expired (tmr_exp)
    );

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    dis_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dir_q) |-> !err);

    // R10
    noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && cfg_mode == MODE_OFF && !reg_we)
        |=> (done && $stable(mode_out)));

    // R7
    expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POLL && tmr_exp && !hit) |=> (done && (err == dir_q)));

    // R11
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && req_valid) |=> busy);
endmodule

// File: tb/mclk_seq_tb.sv
module mclk_seq_tb;
    localparam int DW  = 32;
    localparam int ENL = 20;
    localparam int DSL = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_on = 1'b0, skip_wait = 1'b0;
    logic [1:0]    cfg_mode = 2'b00, mod_status = 2'b00;
    logic          tick_us = 1'b0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [1:0]    mode_out;
    logic          enabled, busy, done, err, tmo_warn;

    int checks = 0, failures = 0;
    int cyc = 0, req_cyc = 0, last_lat = 0, done_cnt = 0;
    logic prev_done = 1'b0;
    logic finished = 1'b0;
    logic [DW-1:0] exp_reg = '0;
    logic [DW+1:0] sb_q[$];

    mclk_seq #(.DW(DW), .EN_LIMIT_US(ENL), .DIS_LIMIT_US(DSL)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .cfg_mode(cfg_mode), .skip_wait(skip_wait), .mod_status(mod_status),
        .tick_us(tick_us), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode_out(mode_out), .enabled(enabled),
        .busy(busy), .done(done), .err(err), .tmo_warn(tmo_warn)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick_us <= ~tick_us;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(1'b0, "R13 done longer than one cycle", 1, 0);
            if (done) begin
                done_cnt++;
                last_lat = cyc - req_cyc;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11 done with no accepted request", 1, 0);
                end else begin
                    logic [DW+1:0] e;
                    logic [DW-1:0] rd;
                    e = sb_q.pop_front();
                    rd = reg_rdata & ~(32'h3 << 16);
                    check({err, tmo_warn, rd} == e, "R3 R4 R7 R8 done outcome",
                          {err, tmo_warn, rd}, e);
                end
            end
        end
        prev_done <= done;
    end

    task automatic sw_write(input logic [DW-1:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        exp_reg = v & ~(32'h3 << 16);
    endtask

    task automatic request(input logic on, input logic [1:0] enc, input logic skip,
                           input logic e_err, input logic e_warn);
        if (enc != 2'b00) exp_reg[1:0] = on ? enc : 2'b00;
        sb_q.push_back({e_err, e_warn, exp_reg});
        @(negedge clk);
        req_valid = 1'b1; req_on = on; cfg_mode = enc; skip_wait = skip;
        req_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 400 && done_cnt < target; i++) @(negedge clk);
        @(negedge clk);
        check(done_cnt == target, "R13 done count", done_cnt, target);
        check(!busy, "R11 busy low after done", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(reg_rdata == 0 && !busy && !done && !err && !tmo_warn && !enabled,
              "R1 reset state", {reg_rdata, busy, done, err, tmo_warn}, 0);

        // R2
        mod_status = 2'b10;
        sw_write(32'hFFFF_FFFC);
        check(reg_rdata == 32'hFFFE_FFFC, "R2 readback with live status", reg_rdata, 32'hFFFE_FFFC);
        sw_write(32'h1234_5670);

        // R3 R5: software enable, status 10 ready
        request(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        wait_done(1);
        check(last_lat == 3, "R5 enable latency", last_lat, 3);
        check(reg_rdata[1:0] == 2'b10 && enabled, "R3 R12 sw mode set", reg_rdata[1:0], 2'b10);

        // R4 R6: disable, status 11
        mod_status = 2'b11;
        request(1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
        wait_done(2);
        check(last_lat == 3, "R6 disable latency", last_lat, 3);
        check(reg_rdata[15:0] == 16'h5670 && !enabled, "R4 mode cleared", reg_rdata[15:0], 16'h5670);

        // R3 R5 R12: hw enable with status 00
        mod_status = 2'b00;
        request(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        wait_done(3);
        check(enabled, "R12 enabled hw", enabled, 1);
        cfg_mode = 2'b10;
        @(negedge clk);
        check(!enabled, "R12 enabled cleared by mismatched encoding", enabled, 0);

        // R5 R7: enable with status 01 times out with err
        mod_status = 2'b01;
        request(1'b1, 2'b10, 1'b0, 1'b1, 1'b0);
        wait_done(4);
        check(last_lat >= 2 * ENL && last_lat <= 2 * ENL + 5, "R7 enable timeout window", last_lat, 2 * ENL);

        // R7: timer restarts; ready just before a non-restarted budget would expire
        mod_status = 2'b11;
        request(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        repeat (2 * ENL - 8) @(negedge clk);
        mod_status = 2'b00;
        wait_done(5);

        // R6 R8: disable with status 10 times out with warning only
        mod_status = 2'b10;
        request(1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
        wait_done(6);
        check(last_lat >= 2 * DSL && last_lat <= 2 * DSL + 5, "R8 disable timeout window", last_lat, 2 * DSL);

        // R5 R11: enable waits on 11, a disable request mid-wait is refused
        mod_status = 2'b11;
        request(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(busy, "R11 busy while waiting", busy, 1);
        req_valid = 1'b1; req_on = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        mod_status = 2'b10;
        wait_done(7);
        repeat (3) @(negedge clk);
        check(done_cnt == 7 && reg_rdata[1:0] == 2'b10, "R11 refused request ignored", reg_rdata[1:0], 2'b10);

        // R9: skip wait, status would never match
        mod_status = 2'b01;
        request(1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
        wait_done(8);
        check(last_lat == 2, "R9 skip latency", last_lat, 2);

        // R10: zero encoding is a no-op
        sw_write(32'h0000_00A1);
        request(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        wait_done(9);
        check(last_lat == 1, "R10 no-op latency", last_lat, 1);
        check(reg_rdata[15:0] == 16'h00A1, "R10 register unchanged", reg_rdata[15:0], 16'h00A1);

        check(sb_q.size() == 0, "R13 scoreboard drained", sb_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 9);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule